// File: doc/BRIEF.md
# Calendar Timekeeper with Update Cycle

This block holds wall-clock time and calendar date as eight byte-wide fields: seconds, minutes, hours, day of week, day of month, month, year within the century, and century. It is fed by an enable tick at 32.768 kHz, divides that down to one step per second, and ripples the step through the fields with correct month lengths, leap Februaries, and year-to-century carry. Each field is shown either as packed BCD or as plain binary. Hours are shown either in 24-hour form or in 12-hour form with a PM flag.

Software-side logic drives plain control levels: a three-bit divider control, a hold bit that freezes counting, a number-format bit and an hour-format bit. It also drives one write strobe per field together with a shared data byte. A status output warns of an approaching step, so a reader can avoid a torn read. A one-cycle pulse reports each completed step to the flag logic elsewhere in the chip. Alarm matching, periodic interrupts and the register bus are outside this block.

The time is held internally in binary. Formatting is applied on the way out, and the reverse conversion is applied to write data under the formats selected at the moment of the write.

Top module: `cal_timekeeper`

## Requirements
- R1: Counting runs only while `set_mode` is 0 and `div_ctl` is at most 3'b010. Values 3'b011 freeze the sub-second phase. Values 3'b110 and 3'b111 hold the phase at zero.
- R2: While running, the seconds step once per TICKS_PER_SEC enabled ticks. `upd_pulse_o` is high for exactly one clock, in the cycle the stepped value first appears.
- R3: When `div_ctl` leaves 3'b11x for a running value with `set_mode` 0, the first step follows after TICKS_PER_SEC/2 ticks.
- R4: `uip_o` is 1 for the last UIP_TICKS ticks before each step and 0 otherwise. It is always 0 while not running.
- R5: With `bin_mode` 0 every field reads as packed BCD (tens in bits 7:4, units in bits 3:0). With `bin_mode` 1 every field reads as plain binary.
- R6: With `h24_mode` 0 the hour field reads 1 to 12 with bit 7 set for PM. Midnight reads as 12 with bit 7 clear, and noon reads as 12 with bit 7 set.
- R7: Seconds and minutes wrap 59 to 0 and hours wrap 23 to 0, each carrying into the next field. Day of week counts 1 to 7 and steps with each day carry.
- R8: Day of month wraps at the month length: 30 for months 4, 6, 9 and 11, 31 for the other months, and for month 2 either 29 (when the year is divisible by 4) or 28.
- R9: Month wraps 12 to 1 into the year. Year wraps 99 to 0 and increments the century.
- R10: While `set_mode` is 1, no field steps and the sub-second phase holds. Writes still land. Clearing `set_mode` resumes from the held phase.
- R11: A write while running takes effect in the next cycle and restarts the sub-second phase, so the next step follows a full TICKS_PER_SEC ticks later.
- R12: Write data is decoded under the current `bin_mode` and `h24_mode`. In 12-hour form, bit 7 of the data marks PM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| div_ctl | input | 3 | Divider control; 3'b000..3'b010 runs, 3'b11x holds the phase at zero |
| set_mode | input | 1 | Freezes counting so software can load the time |
| bin_mode | input | 1 | 1 = binary fields, 0 = packed BCD |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| wr_strobe | input | 8 | Per-field write: bit 0 sec, 1 min, 2 hour, 3 weekday, 4 date, 5 month, 6 year, 7 century |
| wr_data | input | 8 | Write data, shared by all strobes |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| wday_o | output | 8 | Day of week |
| mday_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year within the century |
| cent_o | output | 8 | Century |
| uip_o | output | 1 | Step about to occur |
| upd_pulse_o | output | 1 | One-cycle pulse per completed step |

## Verification
The bench targets the following cases:
- The half-second restart after a divider reset. A design that reloads zero instead would step a full second late.
- The phase kept across the hold bit. A design that restarts the phase would step late after release.
- The placement of the eight-tick warning window. An off-by-one would open it early or leave it up during the step cycle.
- The midnight and noon cases of 12-hour form.
- February in leap and non-leap years, thirty-day months, and the year-99 rollover into the century. A wrong comparison limit would skip or repeat a date.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NUM_FIELDS = 8;
  localparam int IDX_SEC    = 0;
  localparam int IDX_MIN    = 1;
  localparam int IDX_HOUR   = 2;
  localparam int IDX_WDAY   = 3;
  localparam int IDX_MDAY   = 4;
  localparam int IDX_MONTH  = 5;
  localparam int IDX_YEAR   = 6;
  localparam int IDX_CENT   = 7;

  typedef logic [7:0] byte_t;

  function automatic byte_t to_bcd(input byte_t v);
    byte_t t;
    byte_t o;
    t = v / 8'd10;
    o = v % 8'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic byte_t from_bcd(input byte_t v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic byte_t enc_field(input byte_t v, input logic bin);
    return bin ? v : to_bcd(v);
  endfunction

  function automatic byte_t dec_field(input byte_t v, input logic bin);
    return bin ? v : from_bcd(v);
  endfunction

  function automatic byte_t enc_hour(input byte_t h, input logic bin, input logic h24);
    byte_t h12;
    h12 = ((h % 8'd12) == 8'd0) ? 8'd12 : (h % 8'd12);
    if (h24) return enc_field(h, bin);
    return enc_field(h12, bin) | ((h >= 8'd12) ? 8'h80 : 8'h00);
  endfunction

  function automatic byte_t dec_hour(input byte_t d, input logic bin, input logic h24);
    byte_t raw;
    raw = dec_field({1'b0, d[6:0]}, bin);
    if (h24) return dec_field(d, bin);
    return (raw % 8'd12) + (d[7] ? 8'd12 : 8'd0);
  endfunction

  function automatic byte_t month_days(input byte_t mon, input byte_t yr);
    case (mon)
      8'd2:                    return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_phase.sv
module cal_phase #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] div_ctl,
  input  logic       set_mode,
  input  logic       restart,
  output logic       sec_step,
  output logic       uip,
  output logic       running
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST     = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF     = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] UIP_FROM = CW'(TICKS_PER_SEC - UIP_TICKS);

  logic [CW-1:0] cnt_q;
  logic          held_q;
  logic          in_reset, run, load_half, restart_run, at_last;

  always_comb begin
    in_reset    = (div_ctl[2:1] == 2'b11);
    run         = !set_mode && (div_ctl <= 3'd2);
    load_half   = held_q && !in_reset && run;
    restart_run = restart && run && !load_half;
    at_last     = (cnt_q == LAST);
    sec_step    = run && tick && at_last && !load_half && !restart_run;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else begin
      held_q <= in_reset;
      if (in_reset)         cnt_q <= '0;
      else if (load_half)   cnt_q <= HALF;
      else if (restart_run) cnt_q <= '0;
      else if (run && tick) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end

  assign running = run;
  assign uip     = run && (cnt_q >= UIP_FROM);

  a_r1_frozen_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !in_reset) |=> $stable(cnt_q));
  a_r2_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |=> (cnt_q == '0));
  a_r4_uip_before_step: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |-> uip);
endmodule

// File: rtl/cal_chain.sv
module cal_chain
  import cal_pkg::*;
#(
  parameter int RESET_CENTURY = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [7:0]      wr_en,
  input  logic [7:0][7:0] wr_val,
  output logic [7:0][7:0] fld,
  output logic            upd_pulse
);
  localparam logic [7:0][7:0] RESET_VALS =
    {8'(RESET_CENTURY), 8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0};
  localparam logic [7:0][7:0] LOW_VALS =
    {8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0};

  logic [7:0][7:0] top_val;
  logic [7:0]      top_hit;
  logic [7:0]      carry;

  always_comb begin
    top_val[IDX_SEC]   = 8'd59;
    top_val[IDX_MIN]   = 8'd59;
    top_val[IDX_HOUR]  = 8'd23;
    top_val[IDX_WDAY]  = 8'd7;
    top_val[IDX_MDAY]  = month_days(fld[IDX_MONTH], fld[IDX_YEAR]);
    top_val[IDX_MONTH] = 8'd12;
    top_val[IDX_YEAR]  = 8'd99;
    top_val[IDX_CENT]  = 8'd99;
    for (int i = 0; i < NUM_FIELDS; i++) top_hit[i] = (fld[i] >= top_val[i]);
    carry[IDX_SEC]   = step;
    carry[IDX_MIN]   = carry[IDX_SEC]   && top_hit[IDX_SEC];
    carry[IDX_HOUR]  = carry[IDX_MIN]   && top_hit[IDX_MIN];
    carry[IDX_WDAY]  = carry[IDX_HOUR]  && top_hit[IDX_HOUR];
    carry[IDX_MDAY]  = carry[IDX_HOUR]  && top_hit[IDX_HOUR];
    carry[IDX_MONTH] = carry[IDX_MDAY]  && top_hit[IDX_MDAY];
    carry[IDX_YEAR]  = carry[IDX_MONTH] && top_hit[IDX_MONTH];
    carry[IDX_CENT]  = carry[IDX_YEAR]  && top_hit[IDX_YEAR];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld       <= RESET_VALS;
      upd_pulse <= 1'b0;
    end else begin
      upd_pulse <= step;
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (wr_en[i])      fld[i] <= wr_val[i];
        else if (carry[i]) fld[i] <= top_hit[i] ? LOW_VALS[i] : fld[i] + 8'd1;
      end
    end
  end

  a_r7_wday_range: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wr_en == '0 && fld[IDX_WDAY] >= 8'd1 && fld[IDX_WDAY] <= 8'd7)
    |=> (fld[IDX_WDAY] >= 8'd1 && fld[IDX_WDAY] <= 8'd7));
  a_r8_mday_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wr_en == '0 && fld[IDX_MDAY] >= 8'd1 &&
     fld[IDX_MDAY] <= month_days(fld[IDX_MONTH], fld[IDX_YEAR]))
    |=> (fld[IDX_MDAY] >= 8'd1 && fld[IDX_MDAY] <= 8'd31));
  a_r9_century_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wr_en == '0 && fld[IDX_SEC] == 8'd59 && fld[IDX_MIN] == 8'd59 &&
     fld[IDX_HOUR] == 8'd23 && fld[IDX_MDAY] == 8'd31 && fld[IDX_MONTH] == 8'd12 &&
     fld[IDX_YEAR] == 8'd99 && fld[IDX_CENT] < 8'd99)
    |=> (fld[IDX_CENT] == $past(fld[IDX_CENT]) + 8'd1 && fld[IDX_YEAR] == 8'd0));
endmodule

// File: rtl/cal_codec.sv
module cal_codec
  import cal_pkg::*;
(
  input  logic            bin_mode,
  input  logic            h24_mode,
  input  logic [7:0][7:0] fld,
  input  logic [7:0]      wr_data,
  output logic [7:0][7:0] enc_fld,
  output logic [7:0][7:0] wr_val
);
  byte_t enc_u [NUM_FIELDS];
  byte_t dec_u [NUM_FIELDS];

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    if (i == IDX_HOUR) begin : g_hour
      assign enc_u[i] = enc_hour(fld[i], bin_mode, h24_mode);
      assign dec_u[i] = dec_hour(wr_data, bin_mode, h24_mode);
    end else begin : g_plain
      assign enc_u[i] = enc_field(fld[i], bin_mode);
      assign dec_u[i] = dec_field(wr_data, bin_mode);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) begin
      enc_fld[i] = enc_u[i];
      wr_val[i]  = dec_u[i];
    end
  end
endmodule

// File: rtl/cal_timekeeper.sv
module cal_timekeeper
  import cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8,
  parameter int RESET_CENTURY = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic [2:0] div_ctl,
  input  logic       set_mode,
  input  logic       bin_mode,
  input  logic       h24_mode,
  input  logic [7:0] wr_strobe,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [7:0] cent_o,
  output logic       uip_o,
  output logic       upd_pulse_o
);
  logic            sec_step, running;
  logic [7:0][7:0] fld_bin, fld_enc, wr_val;

  cal_phase #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_TICKS(UIP_TICKS)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .div_ctl(div_ctl),
    .set_mode(set_mode), .restart(|wr_strobe), .sec_step(sec_step),
    .uip(uip_o), .running(running)
  );

  cal_chain #(.RESET_CENTURY(RESET_CENTURY)) u_chain (
    .clk(clk), .rst_n(rst_n), .step(sec_step), .wr_en(wr_strobe),
    .wr_val(wr_val), .fld(fld_bin), .upd_pulse(upd_pulse_o)
  );

  cal_codec u_codec (
    .bin_mode(bin_mode), .h24_mode(h24_mode), .fld(fld_bin),
    .wr_data(wr_data), .enc_fld(fld_enc), .wr_val(wr_val)
  );

  assign sec_o   = fld_enc[IDX_SEC];
  assign min_o   = fld_enc[IDX_MIN];
  assign hour_o  = fld_enc[IDX_HOUR];
  assign wday_o  = fld_enc[IDX_WDAY];
  assign mday_o  = fld_enc[IDX_MDAY];
  assign month_o = fld_enc[IDX_MONTH];
  assign year_o  = fld_enc[IDX_YEAR];
  assign cent_o  = fld_enc[IDX_CENT];

  a_r2_pulse_after_uip: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse_o |-> $past(uip_o));
  a_r10_hold_in_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && wr_strobe == '0) |=> $stable(fld_bin));
  a_r1_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !upd_pulse_o);
endmodule

// File: tb/tb_cal_timekeeper.sv
module tb_cal_timekeeper;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 32;
  localparam int UIPW       = 8;

  logic       clk = 1'b0;
  logic       rst_n, tick_32k, set_mode, bin_mode, h24_mode;
  logic [2:0] div_ctl;
  logic [7:0] wr_strobe, wr_data;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o, cent_o;
  logic       uip_o, upd_pulse_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_timekeeper #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPW), .RESET_CENTURY(20)) dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .div_ctl(div_ctl),
    .set_mode(set_mode), .bin_mode(bin_mode), .h24_mode(h24_mode),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o), .month_o(month_o),
    .year_o(year_o), .cent_o(cent_o), .uip_o(uip_o), .upd_pulse_o(upd_pulse_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    wr_strobe = 8'b1 << idx;
    wr_data   = d;
    @(posedge clk);
    @(negedge clk);
    wr_strobe = '0;
  endtask

  task automatic wait_pulse(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!upd_pulse_o && k < 200);
  endtask

  task automatic set_time(input logic [7:0] h, mi, s, wd, md, mo, yr, ce);
    wr(2, h); wr(1, mi); wr(3, wd); wr(4, md);
    wr(5, mo); wr(6, yr); wr(7, ce); wr(0, s);
  endtask

  task automatic t_reset();
    chk("R5 reset sec", sec_o, 8'h00);
    chk("R5 reset hour", hour_o, 8'h00);
    chk("R7 reset wday", wday_o, 8'h01);
    chk("R8 reset date", {mday_o, month_o, year_o}, 24'h010100);
    chk("R9 reset century", cent_o, 8'h20);
    chk("R4 reset uip", uip_o, 1'b0);
  endtask

  task automatic t_period();
    int k;
    wr(0, 8'h10);
    wait_pulse(k);
    chk("R2 first period", k, TPS);
    chk("R2 sec after step", sec_o, 8'h11);
    @(negedge clk);
    chk("R2 pulse one cycle", upd_pulse_o, 1'b0);
    wait_pulse(k);
    chk("R2 second period", k, TPS - 1);
    chk("R2 sec after second step", sec_o, 8'h12);
  endtask

  task automatic t_uip();
    int first = -1;
    int n = 0;
    wr(0, 8'h00);
    for (int k = 1; k <= TPS; k++) begin
      @(negedge clk);
      if (uip_o) begin
        if (first < 0) first = k;
        n++;
      end
    end
    chk("R4 uip window start", first, TPS - UIPW);
    chk("R4 uip window length", n, UIPW);
  endtask

  task automatic t_release();
    int k;
    int np = 0;
    int nu = 0;
    wr(0, 8'h20);
    div_ctl = 3'b110;
    repeat (20) begin
      @(negedge clk);
      if (upd_pulse_o) np++;
      if (uip_o) nu++;
    end
    chk("R3 no step in divider reset", np, 0);
    chk("R4 uip low in divider reset", nu, 0);
    div_ctl = 3'b010;
    wait_pulse(k);
    chk("R3 half second after release", k, TPS/2 + 1);
    chk("R3 sec after release", sec_o, 8'h21);
  endtask

  task automatic t_freeze();
    int k;
    int np = 0;
    int nu = 0;
    wr(0, 8'h40);
    div_ctl = 3'b011;
    repeat (80) begin
      @(negedge clk);
      if (upd_pulse_o) np++;
      if (uip_o) nu++;
    end
    chk("R1 no step with divider 011", np, 0);
    chk("R1 uip low with divider 011", nu, 0);
    chk("R1 sec frozen", sec_o, 8'h40);
    div_ctl = 3'b010;
    wait_pulse(k);
  endtask

  task automatic t_set();
    int k;
    int np = 0;
    wr(0, 8'h05);
    repeat (10) @(negedge clk);
    set_mode = 1'b1;
    repeat (100) begin
      @(negedge clk);
      if (upd_pulse_o) np++;
    end
    chk("R10 no step in set", np, 0);
    chk("R10 sec held", sec_o, 8'h05);
    chk("R4 uip low in set", uip_o, 1'b0);
    wr(1, 8'h44);
    chk("R10 write lands in set", min_o, 8'h44);
    set_mode = 1'b0;
    wait_pulse(k);
    chk("R10 phase kept across set", k, TPS - 10);
    chk("R10 sec after resume", sec_o, 8'h06);
  endtask

  task automatic t_restart();
    int k;
    wait_pulse(k);
    repeat (20) @(negedge clk);
    wr(0, 8'h30);
    chk("R11 write immediate", sec_o, 8'h30);
    wait_pulse(k);
    chk("R11 phase restarted", k, TPS);
    chk("R11 sec after restart", sec_o, 8'h31);
  endtask

  task automatic t_binary();
    int k;
    bin_mode = 1'b1;
    wr(0, 8'd45);
    chk("R12 binary write sec", sec_o, 8'd45);
    wr(1, 8'd59);
    chk("R12 binary write min", min_o, 8'd59);
    bin_mode = 1'b0;
    #1;
    chk("R5 bcd view sec", sec_o, 8'h45);
    chk("R5 bcd view min", min_o, 8'h59);
    bin_mode = 1'b1;
    wait_pulse(k);
    chk("R5 binary count", sec_o, 8'd46);
    bin_mode = 1'b0;
  endtask

  task automatic t_hour12();
    wr(2, 8'h00);
    h24_mode = 1'b0;
    #1;
    chk("R6 midnight as 12 AM", hour_o, 8'h12);
    h24_mode = 1'b1;
    wr(2, 8'h13);
    h24_mode = 1'b0;
    #1;
    chk("R6 13h as 1 PM", hour_o, 8'h81);
    wr(2, 8'h92);
    h24_mode = 1'b1;
    #1;
    chk("R12 12 PM write is noon", hour_o, 8'h12);
    h24_mode = 1'b0;
    #1;
    chk("R6 noon as 12 PM", hour_o, 8'h92);
    wr(2, 8'h12);
    h24_mode = 1'b1;
    #1;
    chk("R12 12 AM write is midnight", hour_o, 8'h00);
  endtask

  task automatic t_rollover();
    int k;
    set_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h14, 8'h03, 8'h25, 8'h20);
    wait_pulse(k);
    chk("R7 time wraps", {hour_o, min_o, sec_o}, 24'h000000);
    chk("R7 weekday 7 to 1", wday_o, 8'h01);
    chk("R7 date steps", mday_o, 8'h15);
  endtask

  task automatic day_roll(input logic [7:0] md, mo, yr, exp_md, exp_mo, input string tag);
    int k;
    set_time(8'h23, 8'h59, 8'h59, 8'h02, md, mo, yr, 8'h20);
    wait_pulse(k);
    chk(tag, {mday_o, month_o}, {exp_md, exp_mo});
  endtask

  task automatic t_months();
    day_roll(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, "R8 feb 28 common year");
    day_roll(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, "R8 feb 28 leap year");
    day_roll(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, "R8 feb 29 leap year");
    day_roll(8'h30, 8'h04, 8'h24, 8'h01, 8'h05, "R8 april 30");
    day_roll(8'h30, 8'h01, 8'h24, 8'h31, 8'h01, "R8 january 30");
    day_roll(8'h31, 8'h01, 8'h24, 8'h01, 8'h02, "R8 january 31");
  endtask

  task automatic t_century();
    int k;
    set_time(8'h23, 8'h59, 8'h59, 8'h03, 8'h31, 8'h12, 8'h99, 8'h20);
    wait_pulse(k);
    chk("R9 year wraps", year_o, 8'h00);
    chk("R9 century steps", cent_o, 8'h21);
    chk("R9 new year date", {mday_o, month_o}, 16'h0101);
  endtask

  initial begin
    rst_n = 1'b0; tick_32k = 1'b1; div_ctl = 3'b010; set_mode = 1'b0;
    bin_mode = 1'b0; h24_mode = 1'b1; wr_strobe = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_period();
    t_uip();
    t_release();
    t_freeze();
    t_set();
    t_restart();
    t_binary();
    t_hour12();
    t_rollover();
    t_months();
    t_century();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL all watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule